// File: doc/BRIEF.md
# E1 Receive CRC-4 Checker with Far-End Block Error Monitor

This block sits on the receive side of an E1 link whose frame and CRC-4 multiframe alignment are already found by other logic. It is fed one received bit per enabled cycle, together with a strobe that marks the first bit of each frame, the number of the current frame within the 16-frame multiframe, and a flag that says multiframe alignment is held. It does no alignment search of its own.

For each submultiframe (eight frames), the block computes a CRC-4 over the received bits. It keeps that result until the following submultiframe has delivered its four check bits, and then compares the two. A mismatch raises a one-cycle pulse and increments a saturating error counter. In the same pass it picks out the two far-end error indication bits of each multiframe. It counts every one that arrives as zero in a second saturating counter. That count goes on even when the submultiframe carrying those bits fails its own check. Both activities stop while alignment is lost. A synchronous clear input empties both counters.

Top module: `e1_crc4_mon`

## Requirements
- R1: The CRC-4 of a submultiframe uses the generator x^4 + x + 1 with x^4 premultiplication. It is computed serially over every enabled bit of the submultiframe, with bit 1 of each even-numbered frame treated as 0. The register starts from zero at the first bit of frame 0 or frame 8. The coefficient of x^3 is C1.
- R2: The check bits are read from bit 1 (the bit marked by `frm_start`) of frames 0, 2, 4, 6 in the first half of the multiframe and of frames 8, 10, 12, 14 in the second half, in the order C1, C2, C3, C4. Each set of check bits is compared with the CRC of the submultiframe received just before it.
- R3: A comparison happens on the first bit of the submultiframe that follows the one holding the check bits. If the two differ, `crc_err_p` is high for exactly the one clock after that bit's clock edge. Otherwise it stays low.
- R4: `crc_err_cnt` rises by one on the same edge that sets `crc_err_p`. It holds at 2^CNT_W-1 once it reaches that value, and it does not change otherwise.
- R5: The far-end error bits are bit 1 of frames 13 and 15. Each one received as 0 raises `ebit_err_cnt` by one, saturating at 2^CNT_W-1. A value of 1 leaves the counter unchanged.
- R6: Far-end error bits are counted whether or not the submultiframe that carries them passes its CRC check.
- R7: While `mf_aligned` is low, no comparison takes place, `crc_err_p` stays low and `ebit_err_cnt` holds.
- R8: After `mf_aligned` rises, the first submultiframe start only begins accumulation. The second completes the first full CRC, and its comparison is skipped. The first comparison happens at the third start.
- R9: A high `clr_cnt` sets both counters to 0 on the next edge and takes priority over any increment on that edge.
- R10: Cycles with `bit_vld` low change no state, whatever the other inputs hold.
- R11: After reset, `crc_err_p`, `crc_err_cnt` and `ebit_err_cnt` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | One received bit is present this cycle |
| rx_bit | input | 1 | Received serial bit |
| frm_start | input | 1 | Current bit is bit 1 of a frame |
| frm_num | input | 4 | Frame number within the multiframe, 0 to 15 |
| mf_aligned | input | 1 | CRC-4 multiframe alignment is held |
| clr_cnt | input | 1 | Synchronous clear of both counters |
| crc_err_p | output | 1 | One-cycle pulse per errored submultiframe |
| crc_err_cnt | output | CNT_W | Saturating count of errored submultiframes |
| ebit_err_cnt | output | CNT_W | Saturating count of far-end error bits received as 0 |

## Verification
The bench first checks the one-submultiframe deferral. A corrupted data bit must be reported at the start of the submultiframe two later, not the next one. A design that compared one submultiframe early, or that failed to zero the check-bit positions, would pulse on clean traffic.

It then covers alignment. It drops alignment while feeding bad check bits and zero error bits, and confirms that nothing is counted. On realignment, a design that skipped too few comparisons would report a stale CRC as an error.

It corrupts the submultiframe that carries zero error bits; a design that gated the far-end count on the local check result would miss those bits. It drives idle cycles that look like a frame-0 start; a design that ignored `bit_vld` would advance its CRC or its stage. Finally, it runs both counters into saturation, where a wrapping counter would return to zero.

// File: rtl/e1_crc4_pkg.sv
package e1_crc4_pkg;
  localparam int CRC_W      = 4;
  localparam int FRM_NUM_W  = 4;
  localparam int SMF_LOG2   = 3;                 // eight frames per submultiframe
  localparam int CIDX_W     = SMF_LOG2 - 1;      // four check bits per submultiframe
  localparam logic [CRC_W-1:0] CRC_TAPS = 4'b0011;  // x + 1 terms of x^4 + x + 1
  localparam logic [FRM_NUM_W-1:0] EBIT_FRM_LO = 4'd13;
  localparam logic [FRM_NUM_W-1:0] EBIT_FRM_HI = 4'd15;

  typedef enum logic [1:0] {
    STG_IDLE  = 2'd0,   // not aligned, nothing accumulated
    STG_PRIME = 2'd1,   // accumulating first complete submultiframe
    STG_ARMED = 2'd2    // a prior CRC is held, comparisons are live
  } cmp_stage_t;

  // One serial step of the premultiplied CRC: feedback is MSB xor data.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] r, input logic d);
    logic fb;
    fb = r[CRC_W-1] ^ d;
    return {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_TAPS : '0);
  endfunction
endpackage

// File: rtl/crc4_accum.sv
module crc4_accum
  import e1_crc4_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_vld,
  input  logic                 rx_bit,
  input  logic                 frm_start,
  input  logic [FRM_NUM_W-1:0] frm_num,
  output logic                 smf_edge,
  output logic [CRC_W-1:0]     crc_run,
  output logic [CRC_W-1:0]     c_run
);
  logic              c_pos;
  logic              din;
  logic [CIDX_W-1:0] c_idx;

  assign smf_edge = bit_vld & frm_start & (frm_num[SMF_LOG2-1:0] == '0);
  assign c_pos    = frm_start & ~frm_num[0];
  assign din      = c_pos ? 1'b0 : rx_bit;
  // even frame 0 -> C1 (MSB), frame 6 -> C4 (LSB)
  assign c_idx    = CIDX_W'(CRC_W-1) - frm_num[SMF_LOG2-1:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_run <= '0;
      c_run   <= '0;
    end else if (bit_vld) begin
      crc_run <= crc_step(smf_edge ? '0 : crc_run, din);
      if (c_pos) c_run[c_idx] <= rx_bit;
    end
  end
endmodule

// File: rtl/smf_cmp_ctrl.sv
module smf_cmp_ctrl
  import e1_crc4_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             mf_aligned,
  input  logic             smf_edge,
  input  logic [CRC_W-1:0] crc_run,
  input  logic [CRC_W-1:0] c_run,
  output logic             err_hit,
  output logic             err_p
);
  cmp_stage_t       stage;
  logic [CRC_W-1:0] crc_prev;

  assign err_hit = mf_aligned & smf_edge & (stage == STG_ARMED) & (c_run != crc_prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage    <= STG_IDLE;
      crc_prev <= '0;
      err_p    <= 1'b0;
    end else begin
      err_p <= err_hit;
      if (smf_edge) crc_prev <= crc_run;
      if (!mf_aligned) begin
        stage <= STG_IDLE;
      end else if (smf_edge) begin
        case (stage)
          STG_IDLE:  stage <= STG_PRIME;
          STG_PRIME: stage <= STG_ARMED;
          default:   stage <= STG_ARMED;
        endcase
      end
    end
  end
endmodule

// File: rtl/sat_cnt.sv
module sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)                  cnt <= '0;
    else if (inc && cnt != CNT_MAX)  cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/e1_crc4_mon.sv
module e1_crc4_mon
  import e1_crc4_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_vld,
  input  logic                 rx_bit,
  input  logic                 frm_start,
  input  logic [FRM_NUM_W-1:0] frm_num,
  input  logic                 mf_aligned,
  input  logic                 clr_cnt,
  output logic                 crc_err_p,
  output logic [CNT_W-1:0]     crc_err_cnt,
  output logic [CNT_W-1:0]     ebit_err_cnt
);
  localparam int N_CNT = 2;

  logic             smf_edge;
  logic [CRC_W-1:0] crc_run;
  logic [CRC_W-1:0] c_run;
  logic             err_hit;
  logic             ebit_hit;
  logic [N_CNT-1:0] inc_v;
  logic [CNT_W-1:0] cnt_v [N_CNT];

  crc4_accum u_accum (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .rx_bit(rx_bit),
    .frm_start(frm_start), .frm_num(frm_num),
    .smf_edge(smf_edge), .crc_run(crc_run), .c_run(c_run)
  );

  smf_cmp_ctrl u_cmp (
    .clk(clk), .rst(rst), .mf_aligned(mf_aligned), .smf_edge(smf_edge),
    .crc_run(crc_run), .c_run(c_run), .err_hit(err_hit), .err_p(crc_err_p)
  );

  // Far-end error bits count regardless of local CRC result
  assign ebit_hit = bit_vld & frm_start & mf_aligned & ~rx_bit &
                    ((frm_num == EBIT_FRM_LO) | (frm_num == EBIT_FRM_HI));

  assign inc_v = {ebit_hit, err_hit};

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    sat_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .clr(clr_cnt), .inc(inc_v[g]), .cnt(cnt_v[g])
    );
  end

  assign crc_err_cnt  = cnt_v[0];
  assign ebit_err_cnt = cnt_v[1];
endmodule

// File: rtl/e1_crc4_mon_chk.sv
module e1_crc4_mon_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_vld,
  input logic             frm_start,
  input logic [3:0]       frm_num,
  input logic             mf_aligned,
  input logic             clr_cnt,
  input logic             crc_err_p,
  input logic [CNT_W-1:0] crc_err_cnt,
  input logic [CNT_W-1:0] ebit_err_cnt
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  // R3
  pulse_after_edge_chk: assert property (@(posedge clk) disable iff (rst)
    crc_err_p |-> $past(bit_vld && frm_start && frm_num[2:0] == 3'd0 && mf_aligned));

  // R4
  crc_cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (crc_err_p && !$past(clr_cnt) && $past(crc_err_cnt) != CMAX)
      |-> crc_err_cnt == $past(crc_err_cnt) + CNT_W'(1));

  // R4
  crc_cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!crc_err_p && !$past(clr_cnt)) |-> $stable(crc_err_cnt));

  // R4
  crc_cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (crc_err_cnt == CMAX && !clr_cnt) |=> crc_err_cnt == CMAX);

  // R7
  ebit_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(mf_aligned) && !$past(clr_cnt)) |-> $stable(ebit_err_cnt));

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_cnt |=> (crc_err_cnt == '0 && ebit_err_cnt == '0));

  // R10
  idle_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> !crc_err_p);

  // R10
  idle_ebit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(bit_vld) && !$past(clr_cnt)) |-> $stable(ebit_err_cnt));
endmodule

bind e1_crc4_mon e1_crc4_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bit_vld(bit_vld), .frm_start(frm_start),
  .frm_num(frm_num), .mf_aligned(mf_aligned), .clr_cnt(clr_cnt),
  .crc_err_p(crc_err_p), .crc_err_cnt(crc_err_cnt), .ebit_err_cnt(ebit_err_cnt)
);

// File: tb/e1_crc4_mon_tb_top.sv
module e1_crc4_mon_tb_top;
  localparam int CW    = 4;
  localparam int FBITS = 32;               // short frames: block relies only on the strobe
  localparam logic [CW-1:0] CMAXV = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_vld = 1'b0, rx_bit = 1'b0, frm_start = 1'b0, mf_aligned = 1'b0, clr_cnt = 1'b0;
  logic [3:0] frm_num = 4'd0;
  logic crc_err_p;
  logic [CW-1:0] crc_err_cnt, ebit_err_cnt;

  int total = 0, bad = 0;
  int fnum = 0, nbits = 0, bst = 0;
  logic [3:0] int_prev = 4'd0, act_prev = 4'd0, act_prev2 = 4'd0, c_last = 4'd0;
  logic [CW-1:0] e_crc = '0, e_eb = '0;

  always #5 clk = ~clk;

  e1_crc4_mon #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .rx_bit(rx_bit), .frm_start(frm_start),
    .frm_num(frm_num), .mf_aligned(mf_aligned), .clr_cnt(clr_cnt),
    .crc_err_p(crc_err_p), .crc_err_cnt(crc_err_cnt), .ebit_err_cnt(ebit_err_cnt)
  );

  function automatic logic [3:0] ref_crc(input logic [3:0] c, input logic d);
    logic top;
    top = c[3];
    c = c << 1;
    if (top ^ d) c = c ^ 4'h3;
    return c;
  endfunction

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v == CMAXV) ? v : v + CW'(1);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input logic fs, input logic [3:0] fn, input logic al);
    nbits++;
    if (nbits % 13 == 0) begin   // R10: idle cycle that mimics a frame-0 start
      @(negedge clk);
      bit_vld = 1'b0; rx_bit = ~b; frm_start = 1'b1; frm_num = 4'd0; mf_aligned = al;
      @(posedge clk); #1;
    end
    @(negedge clk);
    bit_vld = 1'b1; rx_bit = b; frm_start = fs; frm_num = fn; mf_aligned = al;
    @(posedge clk); #1;
  endtask

  // One submultiframe; bad_data flips a payload bit, bad_c flips C2.
  task automatic run_smf(input logic al, input logic bad_data, input logic bad_c,
                         input logic e13, input logic e15);
    logic [3:0] ci, ca, cs;
    logic b, s, exp_p;
    ci = 4'd0; ca = 4'd0;
    cs = int_prev ^ (bad_c ? 4'b0100 : 4'b0000);
    for (int f = 0; f < 8; f++) begin
      for (int k = 0; k < FBITS; k++) begin
        if (k == 0) begin
          if (fnum % 2 == 0)     b = cs[3 - f/2];
          else if (fnum == 13)   b = e13;
          else if (fnum == 15)   b = e15;
          else                   b = (fnum == 5 || fnum == 9 || fnum == 11);
        end else begin
          b = 1'($urandom);
        end
        s = (bad_data && f == 3 && k == 5) ? ~b : b;
        // R1: check-bit positions enter the CRC as 0
        ci = ref_crc(ci, (k == 0 && fnum % 2 == 0) ? 1'b0 : b);
        ca = ref_crc(ca, (k == 0 && fnum % 2 == 0) ? 1'b0 : s);
        send_bit(s, k == 0, 4'(fnum), al);
        if (f == 0 && k == 0) begin
          exp_p = 1'b0;
          if (!al) bst = 0;
          else if (bst == 2) exp_p = (c_last != act_prev2);
          else bst++;
          if (exp_p) e_crc = sat_inc(e_crc);
          check("R3 pulse at submultiframe start", int'(crc_err_p), int'(exp_p));
          check("R4 crc error count", int'(crc_err_cnt), int'(e_crc));
        end
        if (f == 0 && k == 1)
          check("R3 pulse lasts one cycle", int'(crc_err_p), 0);
        if (k == 0 && al && (fnum == 13 || fnum == 15) && !s) e_eb = sat_inc(e_eb);
      end
      fnum = (fnum + 1) % 16;
    end
    int_prev = ci; act_prev2 = act_prev; act_prev = ca; c_last = cs;
    check("R5 far-end count", int'(ebit_err_cnt), int'(e_eb));
  endtask

  task automatic t_reset();
    check("R11 pulse after reset", int'(crc_err_p), 0);
    check("R11 crc count after reset", int'(crc_err_cnt), 0);
    check("R11 ebit count after reset", int'(ebit_err_cnt), 0);
  endtask

  task automatic t_clean();   // R1 R2 R8: clean stream never flags
    for (int i = 0; i < 6; i++) run_smf(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R1 no error on clean stream", int'(crc_err_cnt), 0);
  endtask

  task automatic t_bad_data();  // R3 R4: reported two starts later
    run_smf(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    run_smf(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    run_smf(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R4 one error counted", int'(crc_err_cnt), 1);
  endtask

  task automatic t_bad_c();   // R2: corrupted check bits
    run_smf(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    run_smf(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R2 wrong C bits counted", int'(crc_err_cnt), 2);
  endtask

  task automatic t_ebits_errored();  // R6: E bits in errored submultiframe
    if (fnum != 8) run_smf(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    run_smf(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    run_smf(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    run_smf(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R6 E bits counted in errored block", int'(ebit_err_cnt), 3);
  endtask

  task automatic t_unaligned();  // R7 R8
    logic [CW-1:0] c0, e0;
    c0 = crc_err_cnt; e0 = ebit_err_cnt;
    for (int i = 0; i < 4; i++) run_smf(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R7 no crc count when unaligned", int'(crc_err_cnt), int'(c0));
    check("R7 no ebit count when unaligned", int'(ebit_err_cnt), int'(e0));
    run_smf(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    run_smf(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R8 comparisons skipped after realign", int'(crc_err_cnt), int'(c0));
    run_smf(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_clear();  // R9
    @(negedge clk);
    bit_vld = 1'b0; clr_cnt = 1'b1;
    @(negedge clk);
    clr_cnt = 1'b0;
    e_crc = '0; e_eb = '0;
    check("R9 crc count cleared", int'(crc_err_cnt), 0);
    check("R9 ebit count cleared", int'(ebit_err_cnt), 0);
  endtask

  task automatic t_saturate();  // R4 R5
    for (int i = 0; i < 20; i++) run_smf(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R4 crc count saturates", int'(crc_err_cnt), int'(CMAXV));
    check("R5 ebit count saturates", int'(ebit_err_cnt), int'(CMAXV));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_clean();
    t_bad_data();
    t_bad_c();
    t_ebits_errored();
    t_unaligned();
    t_clear();
    t_saturate();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule